// File: doc/BRIEF.md
# Address-Masked General-Purpose I/O Port

An 8-pin general-purpose I/O port on a simple 32-bit register bus with a 4 KB window. Software writes and reads pin data through a data window in which word-address bits [9:2] act as a per-bit mask. This lets one store change any subset of output pins without a read-modify-write. A direction register chooses, per pin, between driving the stored value and sampling the external level. Input levels pass through a two-flop synchronizer before they reach the data register or the interrupt logic.

Each pin has its own interrupt detector. It can be edge- or level-triggered, with a selectable polarity or both edges. Raw status is gathered and then masked into one interrupt line, and software clears it by writing ones. The alternate-function select register is guarded by a commit mask. That mask can only be rewritten after a 32-bit key has unlocked the port. Eight pad-control words are plain read/write storage. A fixed block of identification bytes sits at the top of the window. An access to an offset that is not in the map reads zero, changes nothing and raises a one-cycle error pulse.

Bus timing: an access is taken on a rising edge where `bus_sel` is high. Read data and the error flag are registered and are valid in the cycle after the access.

Top module: `gpio_mm`

## Requirements
- R1: A read at any offset below 0x400 returns the data register ANDed with the mask formed by address bits [9:2] (bit i of the mask is address bit i+2).
- R2: A write at an offset below 0x400 changes only the data bits whose address-mask bit and direction bit are both 1. Every other data bit keeps its value.
- R3: `pin_out` equals (data AND direction) OR NOT direction at all times, so every input-direction pin (direction bit 0) drives 1.
- R4: For each input-direction pin, the data register follows the synchronized `pin_in` level within three cycles. `pin_in` levels on output-direction pins have no effect on the data register.
- R5: A write of 0x0ACCE551 to offset 0x520 unlocks the port. A write of any other value there locks it. A read of 0x520 returns 1 while locked and 0 while unlocked.
- R6: A write to the commit register at 0x524 takes effect only while the port is unlocked.
- R7: A write to the alternate-function register at 0x420 changes only the bits where the commit register holds 1.
- R8: After reset the port is locked, the commit register is 0xFF, and all other registers are 0. Every pin is therefore an input and `pin_out` is 0xFF.
- R9: Reads of offsets 0xFD0 to 0xFFC return one identification byte per word, in address order: 00,00,00,00,61,00,18,01,0D,F0,05,B1.
- R10: Interrupt configuration is at offset 0x404 (sense: 1 = level), 0x408 (both edges: 1 = either edge) and 0x40C (event: 1 = high level or rising edge, 0 = low level or falling edge). A detected event sets the pin's raw status bit, which reads at 0x414.
- R11: Offset 0x418 reads raw status AND the mask at 0x410. `irq` is 1 exactly when that value is nonzero.
- R12: Writing ones to offset 0x41C clears the matching raw status bits. A level condition that is still present sets its bit again. Offset 0x41C reads as 0.
- R13: An access to an unmapped offset reads 0, changes no register and pulses `bus_err` for exactly one cycle, in the cycle after the access.
- R14: The eight pad-control words at 0x500 to 0x51C store and return their low 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle it is high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse after an unmapped access |
| pin_in | input | 8 | External pin levels, asynchronous |
| pin_out | output | 8 | Pin drive values |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that every access the bus makes is word-aligned. They also assume that `bus_wr`, `bus_addr` and `bus_wdata` are stable at the edge where `bus_sel` is high, and that the synchronizer output is the only path from `pin_in` into the state. The bench keeps to these assumptions. It drives all bus signals and `pin_in` on the falling edge, uses only multiples of four as offsets, and allows at least five cycles after each pin change before it reads data or interrupt status.

// File: rtl/gpio_mm_pkg.sv
// Package: constants and the identification lookup for the address-masked GPIO port.
// Assumes a 12-bit byte offset and word-aligned accesses.
package gpio_mm_pkg;
    localparam int ADDR_W    = 12;
    localparam int BUS_W     = 32;
    localparam int PAD_COUNT = 8;
    localparam int PAD_IDX_W = $clog2(PAD_COUNT);

    localparam logic [ADDR_W-1:0] OFF_DIR    = 12'h400;
    localparam logic [ADDR_W-1:0] OFF_SENSE  = 12'h404;
    localparam logic [ADDR_W-1:0] OFF_BOTH   = 12'h408;
    localparam logic [ADDR_W-1:0] OFF_EVT    = 12'h40C;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 12'h410;
    localparam logic [ADDR_W-1:0] OFF_RAW    = 12'h414;
    localparam logic [ADDR_W-1:0] OFF_MSTAT  = 12'h418;
    localparam logic [ADDR_W-1:0] OFF_CLR    = 12'h41C;
    localparam logic [ADDR_W-1:0] OFF_ALT    = 12'h420;
    localparam logic [ADDR_W-1:0] OFF_KEY    = 12'h520;
    localparam logic [ADDR_W-1:0] OFF_COMMIT = 12'h524;
    localparam logic [6:0]        PAD_TAG    = 7'b0101000;  // offsets 0x500..0x51C
    localparam logic [9:0]        ID_WORD0   = 10'h3F4;     // word index of 0xFD0

    localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h0ACC_E551;

    // Identification byte for word index 0..11 of the top block.
    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        case (idx)
            4'd4:    id_byte = 8'h61;
            4'd6:    id_byte = 8'h18;
            4'd7:    id_byte = 8'h01;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/gpio_mm_sync.sv
// Multi-stage synchronizer, one independent chain per bit.
// Assumes din is asynchronous to clk; the output lags by STAGES cycles.
module gpio_mm_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift every bit through its flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mm_irq.sv
// Per-pin interrupt detector and raw status store.
// Assumes lvl is already synchronized. A set in the same cycle as a clear wins.
module gpio_mm_irq #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] sense,
    input  logic [N-1:0] both,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] raw
);
    logic [N-1:0] prev_q;
    logic [N-1:0] hit;

    // One detector per pin, chosen by that pin's configuration bits.
    for (genvar i = 0; i < N; i++) begin : g_det
        logic rise, fall;
        assign rise = lvl[i] & ~prev_q[i];
        assign fall = ~lvl[i] & prev_q[i];
        always_comb begin
            if (sense[i])     hit[i] = (lvl[i] == evt[i]);
            else if (both[i]) hit[i] = rise | fall;
            else              hit[i] = evt[i] ? rise : fall;
        end
    end

    // Track the previous level and accumulate the raw status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            raw    <= '0;
        end else begin
            prev_q <= lvl;
            raw    <= (raw & ~clr) | hit;
        end
    end
endmodule

// File: rtl/gpio_mm.sv
// Top level of the address-masked GPIO port: register decode, data path,
// lock/commit guard, pad storage and identification reads.
// Assumes word-aligned offsets; rdata and err are registered (one-cycle latency).
module gpio_mm
    import gpio_mm_pkg::*;
#(
    parameter int N_PINS      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_err,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic              irq
);
    localparam int W = N_PINS;

    logic [W-1:0] data_q, dir_q, sense_q, both_q, evt_q, mask_q, afsel_q, commit_q;
    logic [PAD_COUNT-1:0][W-1:0] pad_q;
    logic         locked_q;
    logic [W-1:0] sync_in, raw_q, clr_bits, amask;
    logic [ADDR_W-1:0] aligned;
    logic [9:0]   word;
    logic         wr_hit, in_data, in_pad, in_id, mapped;
    logic [BUS_W-1:0] rd_val;

    assign aligned = {bus_addr[ADDR_W-1:2], 2'b00};
    assign word    = bus_addr[ADDR_W-1:2];
    assign amask   = bus_addr[W+1:2];
    assign wr_hit  = bus_sel & bus_wr;
    assign in_data = (bus_addr[11:10] == 2'b00);
    assign in_id   = (word >= ID_WORD0);
    assign in_pad  = (bus_addr[11:5] == PAD_TAG);

    gpio_mm_sync #(.WIDTH(W), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(sync_in)
    );

    assign clr_bits = (wr_hit && aligned == OFF_CLR) ? bus_wdata[W-1:0] : '0;

    gpio_mm_irq #(.N(W)) irq_i (
        .clk(clk), .rst_n(rst_n), .lvl(sync_in), .sense(sense_q),
        .both(both_q), .evt(evt_q), .clr(clr_bits), .raw(raw_q)
    );

    // Drive outputs from the stored data; input pins float high.
    assign pin_out = (data_q & dir_q) | ~dir_q;
    assign irq     = |(raw_q & mask_q);

    // Decode the read value and whether the offset is in the map.
    always_comb begin
        rd_val = '0;
        mapped = 1'b1;
        if (in_data) begin
            rd_val[W-1:0] = data_q & amask;
        end else if (in_id) begin
            rd_val[7:0] = id_byte(4'(word - ID_WORD0));
        end else if (in_pad) begin
            rd_val[W-1:0] = pad_q[bus_addr[PAD_IDX_W+1:2]];
        end else begin
            case (aligned)
                OFF_DIR:    rd_val[W-1:0] = dir_q;
                OFF_SENSE:  rd_val[W-1:0] = sense_q;
                OFF_BOTH:   rd_val[W-1:0] = both_q;
                OFF_EVT:    rd_val[W-1:0] = evt_q;
                OFF_MASK:   rd_val[W-1:0] = mask_q;
                OFF_RAW:    rd_val[W-1:0] = raw_q;
                OFF_MSTAT:  rd_val[W-1:0] = raw_q & mask_q;
                OFF_CLR:    rd_val        = '0;
                OFF_ALT:    rd_val[W-1:0] = afsel_q;
                OFF_KEY:    rd_val[0]     = locked_q;
                OFF_COMMIT: rd_val[W-1:0] = commit_q;
                default:    mapped        = 1'b0;
            endcase
        end
    end

    // Register bus responses: read data and the unmapped-access pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= bus_sel & ~mapped;
            if (bus_sel && !bus_wr) bus_rdata <= rd_val;
        end
    end

    // Data register: masked writes on output pins, sampled levels on input pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            for (int i = 0; i < W; i++) begin
                if (!dir_q[i])                        data_q[i] <= sync_in[i];
                else if (wr_hit && in_data && amask[i]) data_q[i] <= bus_wdata[i];
            end
        end
    end

    // Configuration, guard and pad registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '0;
            sense_q  <= '0;
            both_q   <= '0;
            evt_q    <= '0;
            mask_q   <= '0;
            afsel_q  <= '0;
            commit_q <= '1;
            locked_q <= 1'b1;
            pad_q    <= '0;
        end else if (wr_hit && !in_data && !in_id) begin
            if (in_pad) begin
                pad_q[bus_addr[PAD_IDX_W+1:2]] <= bus_wdata[W-1:0];
            end else begin
                case (aligned)
                    OFF_DIR:    dir_q    <= bus_wdata[W-1:0];
                    OFF_SENSE:  sense_q  <= bus_wdata[W-1:0];
                    OFF_BOTH:   both_q   <= bus_wdata[W-1:0];
                    OFF_EVT:    evt_q    <= bus_wdata[W-1:0];
                    OFF_MASK:   mask_q   <= bus_wdata[W-1:0];
                    OFF_ALT:    afsel_q  <= (afsel_q & ~commit_q) | (bus_wdata[W-1:0] & commit_q);
                    OFF_KEY:    locked_q <= (bus_wdata != UNLOCK_KEY);
                    OFF_COMMIT: if (!locked_q) commit_q <= bus_wdata[W-1:0];
                    default:    ;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_mm_chk.sv
// Checker for the address-masked GPIO port, bound into every gpio_mm instance.
// Assumes the port's internal register names; observes only, drives nothing.
module gpio_mm_chk #(
    parameter int W = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_err,
    input logic [W-1:0] data_q,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] raw_q,
    input logic [W-1:0] afsel_q,
    input logic [W-1:0] commit_q,
    input logic        locked_q
);
    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr < 12'h400) |=> ((data_q ^ $past(data_q)) & $past(dir_q)) == '0);

    // R5
    key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 12'h520 && bus_wdata == 32'h0ACCE551) |=> !locked_q);

    // R6
    commit_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(commit_q));

    // R7
    afsel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((afsel_q ^ $past(afsel_q)) & ~$past(commit_q)) == '0);

    // R12
    raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == 12'h41C) |=> ($past(raw_q) & ~raw_q) == '0);

    // R13
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel));
endmodule

bind gpio_mm gpio_mm_chk #(.W(N_PINS)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_err(bus_err),
    .data_q(data_q), .dir_q(dir_q), .raw_q(raw_q), .afsel_q(afsel_q),
    .commit_q(commit_q), .locked_q(locked_q)
);

// File: tb/gpio_mm_tb_top.sv
// Directed bench for gpio_mm: one task per scenario, each checking its results.
module gpio_mm_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic        irq;
    int checks = 0, failures = 0;
    logic [31:0] rv;
    logic        ev;

    always #2 clk = ~clk;  // 250 MHz

    gpio_mm dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        ev = bus_err;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata; ev = bus_err;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
    endtask

    task automatic t_reset();
        bus_read(12'h520, rv); check("R8 locked at reset", rv, 32'h1);
        bus_read(12'h524, rv); check("R8 commit at reset", rv, 32'hFF);
        bus_read(12'h400, rv); check("R8 dir at reset", rv, 32'h0);
        check("R8 pin_out at reset", {24'h0, pin_out}, 32'hFF);
        check("R8 irq at reset", {31'h0, irq}, 32'h0);
        check("R8 err at reset", {31'h0, ev}, 32'h0);
    endtask

    task automatic t_data();
        bus_write(12'h400, 32'hF0);
        bus_write(12'h3FC, 32'hA5);              // full mask
        check("R3 pin_out mixed", {24'h0, pin_out}, 32'hAF);
        bus_write(12'h0C0, 32'h00);              // mask 0x30
        bus_read(12'h3FC, rv); check("R2 masked write", rv, 32'h80);
        bus_read(12'h300, rv); check("R1 read mask C0", rv, 32'h80);
        bus_read(12'h100, rv); check("R1 read mask 40", rv, 32'h00);
        check("R3 pin_out after write", {24'h0, pin_out}, 32'h8F);
        pin_in = 8'hF6; settle();
        bus_read(12'h03C, rv); check("R4 input pins sampled", rv, 32'h06);
        bus_read(12'h3FC, rv); check("R4 output pins ignore pin_in", rv, 32'h86);
        bus_write(12'h3FC, 32'h0F);              // low bits are inputs
        bus_read(12'h3FC, rv); check("R2 write to input bits no effect", rv, 32'h06);
        check("R3 inputs drive high", {24'h0, pin_out}, 32'h0F);
        pin_in = 8'h00; bus_write(12'h400, 32'h00); settle();
        bus_read(12'h3FC, rv); check("R4 all inputs", rv, 32'h00);
    endtask

    task automatic t_lock();
        bus_write(12'h420, 32'hF0);
        bus_read(12'h420, rv); check("R7 alt write under full commit", rv, 32'hF0);
        bus_write(12'h524, 32'h0F);
        bus_read(12'h524, rv); check("R6 commit locked", rv, 32'hFF);
        bus_write(12'h520, 32'h0ACCE551);
        bus_read(12'h520, rv); check("R5 unlocked read", rv, 32'h0);
        bus_write(12'h524, 32'h0F);
        bus_read(12'h524, rv); check("R6 commit unlocked", rv, 32'h0F);
        bus_write(12'h520, 32'h0ACCE550);
        bus_read(12'h520, rv); check("R5 relock", rv, 32'h1);
        bus_write(12'h524, 32'h00);
        bus_read(12'h524, rv); check("R6 commit relocked", rv, 32'h0F);
        bus_write(12'h420, 32'h0F);
        bus_read(12'h420, rv); check("R7 alt set low", rv, 32'hFF);
        bus_write(12'h420, 32'h00);
        bus_read(12'h420, rv); check("R7 alt high protected", rv, 32'hF0);
    endtask

    task automatic t_id();
        logic [7:0] exp_id [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00,
                                    8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 12; i++) begin
            bus_read(12'hFD0 + 12'(i * 4), rv);
            check($sformatf("R9 id byte %0d", i), rv, {24'h0, exp_id[i]});
        end
    endtask

    task automatic t_irq();
        bus_write(12'h40C, 32'h09);   // pin0 rising, pin1 falling, pin3 high level
        bus_write(12'h408, 32'h04);   // pin2 both edges
        bus_write(12'h404, 32'h08);   // pin3 level
        bus_write(12'h410, 32'h01);
        bus_write(12'h41C, 32'hFF);
        bus_read(12'h414, rv); check("R10 raw idle", rv, 32'h0);
        pin_in = 8'h03; settle();
        bus_read(12'h414, rv); check("R10 rising sets pin0 only", rv, 32'h01);
        bus_read(12'h418, rv); check("R11 masked status", rv, 32'h01);
        check("R11 irq high", {31'h0, irq}, 32'h1);
        bus_write(12'h410, 32'h02);
        check("R11 irq masked off", {31'h0, irq}, 32'h0);
        bus_read(12'h41C, rv); check("R12 clear reads zero", rv, 32'h0);
        bus_write(12'h41C, 32'h01);
        bus_read(12'h414, rv); check("R12 w1c", rv, 32'h0);
        pin_in = 8'h00; settle();
        bus_read(12'h414, rv); check("R10 falling sets pin1", rv, 32'h02);
        check("R11 irq from pin1", {31'h0, irq}, 32'h1);
        bus_write(12'h41C, 32'h02);
        pin_in = 8'h04; settle();
        bus_read(12'h414, rv); check("R10 both rise", rv, 32'h04);
        bus_write(12'h41C, 32'h04);
        pin_in = 8'h00; settle();
        bus_read(12'h414, rv); check("R10 both fall", rv, 32'h04);
        bus_write(12'h41C, 32'h04);
        pin_in = 8'h08; settle();
        bus_write(12'h41C, 32'h08);
        bus_read(12'h414, rv); check("R12 level persists over clear", rv, 32'h08);
        pin_in = 8'h00; settle();
        bus_write(12'h41C, 32'h08);
        bus_read(12'h414, rv); check("R10 level gone after clear", rv, 32'h0);
    endtask

    task automatic t_unmapped();
        bus_read(12'h428, rv);
        check("R13 unmapped reads zero", rv, 32'h0);
        check("R13 err pulse", {31'h0, ev}, 32'h1);
        @(posedge clk); @(negedge clk);
        check("R13 err one cycle", {31'h0, bus_err}, 32'h0);
        bus_write(12'h414, 32'hFF);
        check("R13 read-only offset no err", {31'h0, ev}, 32'h0);
        bus_write(12'h600, 32'hFF);
        check("R13 write err", {31'h0, ev}, 32'h1);
        bus_read(12'h400, rv); check("R13 state untouched", rv, 32'h0);
    endtask

    task automatic t_pads();
        for (int i = 0; i < 8; i++)
            bus_write(12'h500 + 12'(i * 4), 32'(i * 17 + 3));
        for (int i = 0; i < 8; i++) begin
            bus_read(12'h500 + 12'(i * 4), rv);
            check($sformatf("R14 pad %0d", i), rv, 32'(i * 17 + 3));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_data();
        t_lock();
        t_id();
        t_irq();
        t_unmapped();
        t_pads();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule